// File: doc/BRIEF.md
# Transceiver Channel Loopback Steering Controller

This block sits between the system-side byte interface of one 8b/10b serial transceiver channel and the channel's codec, serializer and clock-recovery stages. A 2-bit mode input chooses a path. In the direct path, external transmit controls pass through. In parallel loopback, the received byte is turned around onto the transmit side. In serial loopback, the transmitter's serial bit is fed back into the receiver's clock-recovery input.

In parallel loopback the block builds the whole transmit word from the receive side. It takes the received byte, the received special-character flag and a 3-bit link status code. When the link is lost or resynchronizing, it substitutes the IDLE comma byte 0xBC with the command select raised. Otherwise the command select copies the special-character flag. Control characters therefore come back as control characters, and errored characters come back as plain data. While this path is active, the block also forces the transmit timing mode to zero, takes the receive word clock from the internal reference copy, and drops the receive-output-valid flag. A BIST enable blocks parallel loopback.

A three-state path machine (DIRECT, PLOOP, SLOOP) is clocked on the reference clock. Its next state is decoded from the mode and BIST inputs: mode 01 without BIST goes to PLOOP, mode 10 goes to SLOOP, and every other combination goes to DIRECT. Any state can reach any other state in one clock. All transmit-side and receive-control outputs are registered on the same edge as the state register. The clock-recovery input select follows the registered state through a combinational mux.

Top module: `lbk_channel_ctrl`

## Requirements
- R1: While rst_ni is low, every registered output is 0 and cdr_in_o follows ser_line_rx_i.
- R2: With mode 00, one clock after the inputs are applied, tx_byte_o, tx_cmd_o, tx_k_o, tx_wsync_o and tx_tmode_o equal ext_tx_byte_i, ext_tx_cmd_i, ext_tx_k_i, ext_wsync_en_i and ext_tmode_i. In the same cycle rx_valid_o is 1 and rx_wclk_int_o is 0.
- R3: Mode 11 behaves exactly as mode 00.
- R4: With mode 01 and BIST off, and a link status other than 110 or 111, one clock later tx_byte_o equals rx_byte_i and tx_cmd_o equals rx_kflag_i.
- R5: With mode 01 and BIST off, one clock later tx_k_o is 1, tx_wsync_o is 0, tx_tmode_o is 000, rx_wclk_int_o is 1 and rx_valid_o is 0.
- R6: With mode 01, BIST off and link status 110 (resync) or 111 (loss of signal), one clock later tx_byte_o is 0xBC and tx_cmd_o is 1, whatever rx_byte_i and rx_kflag_i are.
- R7: With mode 01 and BIST off, statuses 010 (disparity error), 011 (out-of-band) and 100 (overflow/underflow) with rx_kflag_i 0 return rx_byte_i with tx_cmd_o 0.
- R8: From the first clock edge that samples mode 10, cdr_in_o equals ser_tx_bit_i. Under any other registered path, cdr_in_o equals ser_line_rx_i.
- R9: ser_out_p_o and ser_out_r_o both equal ser_tx_bit_i in every mode.
- R10: With bist_en_i high, mode 01 behaves as mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Path select: 00 direct, 01 parallel loop, 10 serial loop, 11 treated as 00 |
| bist_en_i | input | 1 | BIST active; blocks parallel loop |
| ext_tx_byte_i | input | 8 | System transmit byte |
| ext_tx_cmd_i | input | 1 | System command/data select |
| ext_tx_k_i | input | 1 | System K-character input |
| ext_wsync_en_i | input | 1 | System word-sync enable |
| ext_tmode_i | input | 3 | System transmit timing mode |
| rx_byte_i | input | 8 | Decoded receive byte |
| rx_kflag_i | input | 1 | Receive special-character flag |
| rx_status_i | input | 3 | Link status code |
| ser_tx_bit_i | input | 1 | Serializer output bit |
| ser_line_rx_i | input | 1 | Serial bit from the line receiver |
| tx_byte_o | output | 8 | Byte to the encoder |
| tx_cmd_o | output | 1 | Command/data select to the encoder |
| tx_k_o | output | 1 | K-character control to the encoder |
| tx_wsync_o | output | 1 | Word-sync enable to the transmitter |
| tx_tmode_o | output | 3 | Transmit timing mode |
| rx_valid_o | output | 1 | Receive output data is usable |
| rx_wclk_int_o | output | 1 | 1: receive word clock from internal reference copy |
| cdr_in_o | output | 1 | Clock-recovery input bit |
| ser_out_p_o | output | 1 | Primary serial output |
| ser_out_r_o | output | 1 | Redundant serial output |

## Verification
Every registered result, meaning the transmit byte, the command select, the K and word-sync controls, the timing mode, the valid flag and the word-clock select, is due on the first rising edge after its inputs are applied. The bench changes inputs on a falling edge and reads these outputs on the next falling edge, half a period after that rising edge. The clock-recovery select also changes at that rising edge, but its data path is combinational. The serial outputs are combinational too. For these, the bench changes the serial bit and reads the result a nanosecond later, without any clock edge in between.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL   = 2'b00,
        LB_PARALLEL = 2'b01,
        LB_SERIAL   = 2'b10,
        LB_RESERVED = 2'b11
    } lb_mode_e;

    typedef enum logic [1:0] {
        PATH_DIRECT = 2'd0,
        PATH_PLOOP  = 2'd1,
        PATH_SLOOP  = 2'd2
    } path_e;

    localparam int unsigned STAT_W = 3;

    localparam logic [STAT_W-1:0] ST_DATA    = 3'b000;
    localparam logic [STAT_W-1:0] ST_SPECIAL = 3'b001;
    localparam logic [STAT_W-1:0] ST_DISP    = 3'b010;
    localparam logic [STAT_W-1:0] ST_OOB     = 3'b011;
    localparam logic [STAT_W-1:0] ST_FLOW    = 3'b100;
    localparam logic [STAT_W-1:0] ST_RESYNC  = 3'b110;
    localparam logic [STAT_W-1:0] ST_LOS     = 3'b111;

endpackage

// File: rtl/lbk_path_fsm.sv
module lbk_path_fsm
    import lbk_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       bist_en_i,
    output path_e      path_d_o,
    output path_e      path_q_o
);

    path_e path_q, path_d;

    always_comb begin
        unique case (lb_mode_e'(mode_i))
            LB_PARALLEL: path_d = bist_en_i ? PATH_DIRECT : PATH_PLOOP;
            LB_SERIAL:   path_d = PATH_SLOOP;
            LB_NORMAL,
            LB_RESERVED: path_d = PATH_DIRECT;
            default:     path_d = PATH_DIRECT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) path_q <= PATH_DIRECT;
        else         path_q <= path_d;
    end

    assign path_d_o = path_d;
    assign path_q_o = path_q;

endmodule

// File: rtl/lbk_loop_word.sv
module lbk_loop_word
    import lbk_pkg::*;
#(
    parameter int unsigned          BYTE_W    = 8,
    parameter logic [BYTE_W-1:0]    IDLE_CODE = 8'hBC
) (
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              rx_kflag_i,
    input  logic [STAT_W-1:0] rx_status_i,
    output logic [BYTE_W-1:0] lp_byte_o,
    output logic              lp_cmd_o
);

    logic link_down;

    assign link_down = (rx_status_i == ST_RESYNC) || (rx_status_i == ST_LOS);

    always_comb begin
        if (link_down) begin
            lp_byte_o = IDLE_CODE;
            lp_cmd_o  = 1'b1;
        end else begin
            lp_byte_o = rx_byte_i;
            lp_cmd_o  = rx_kflag_i;
        end
    end

endmodule

// File: rtl/lbk_serial_route.sv
module lbk_serial_route
    import lbk_pkg::*;
(
    input  path_e path_q_i,
    input  logic  ser_tx_bit_i,
    input  logic  ser_line_rx_i,
    output logic  cdr_in_o,
    output logic  ser_out_p_o,
    output logic  ser_out_r_o
);

    assign cdr_in_o    = (path_q_i == PATH_SLOOP) ? ser_tx_bit_i : ser_line_rx_i;
    assign ser_out_p_o = ser_tx_bit_i;
    assign ser_out_r_o = ser_tx_bit_i;

endmodule

// File: rtl/lbk_channel_ctrl.sv
module lbk_channel_ctrl
    import lbk_pkg::*;
#(
    parameter int unsigned       BYTE_W    = 8,
    parameter int unsigned       TMODE_W   = 3,
    parameter logic [BYTE_W-1:0] IDLE_CODE = 8'hBC
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         mode_i,
    input  logic               bist_en_i,
    input  logic [BYTE_W-1:0]  ext_tx_byte_i,
    input  logic               ext_tx_cmd_i,
    input  logic               ext_tx_k_i,
    input  logic               ext_wsync_en_i,
    input  logic [TMODE_W-1:0] ext_tmode_i,
    input  logic [BYTE_W-1:0]  rx_byte_i,
    input  logic               rx_kflag_i,
    input  logic [STAT_W-1:0]  rx_status_i,
    input  logic               ser_tx_bit_i,
    input  logic               ser_line_rx_i,
    output logic [BYTE_W-1:0]  tx_byte_o,
    output logic               tx_cmd_o,
    output logic               tx_k_o,
    output logic               tx_wsync_o,
    output logic [TMODE_W-1:0] tx_tmode_o,
    output logic               rx_valid_o,
    output logic               rx_wclk_int_o,
    output logic               cdr_in_o,
    output logic               ser_out_p_o,
    output logic               ser_out_r_o
);

    path_e             path_d, path_q;
    logic [BYTE_W-1:0] lp_byte;
    logic              lp_cmd;

    lbk_path_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode_i),
        .bist_en_i (bist_en_i),
        .path_d_o  (path_d),
        .path_q_o  (path_q)
    );

    lbk_loop_word #(
        .BYTE_W    (BYTE_W),
        .IDLE_CODE (IDLE_CODE)
    ) u_word (
        .rx_byte_i   (rx_byte_i),
        .rx_kflag_i  (rx_kflag_i),
        .rx_status_i (rx_status_i),
        .lp_byte_o   (lp_byte),
        .lp_cmd_o    (lp_cmd)
    );

    lbk_serial_route u_ser (
        .path_q_i      (path_q),
        .ser_tx_bit_i  (ser_tx_bit_i),
        .ser_line_rx_i (ser_line_rx_i),
        .cdr_in_o      (cdr_in_o),
        .ser_out_p_o   (ser_out_p_o),
        .ser_out_r_o   (ser_out_r_o)
    );

    // Output process: registered on the same edge as the path state.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_byte_o     <= '0;
            tx_cmd_o      <= 1'b0;
            tx_k_o        <= 1'b0;
            tx_wsync_o    <= 1'b0;
            tx_tmode_o    <= '0;
            rx_valid_o    <= 1'b0;
            rx_wclk_int_o <= 1'b0;
        end else begin
            unique case (path_d)
                PATH_PLOOP: begin
                    tx_byte_o     <= lp_byte;
                    tx_cmd_o      <= lp_cmd;
                    tx_k_o        <= 1'b1;
                    tx_wsync_o    <= 1'b0;
                    tx_tmode_o    <= '0;
                    rx_valid_o    <= 1'b0;
                    rx_wclk_int_o <= 1'b1;
                end
                PATH_DIRECT, PATH_SLOOP: begin
                    tx_byte_o     <= ext_tx_byte_i;
                    tx_cmd_o      <= ext_tx_cmd_i;
                    tx_k_o        <= ext_tx_k_i;
                    tx_wsync_o    <= ext_wsync_en_i;
                    tx_tmode_o    <= ext_tmode_i;
                    rx_valid_o    <= 1'b1;
                    rx_wclk_int_o <= 1'b0;
                end
                default: begin
                    tx_byte_o     <= ext_tx_byte_i;
                    tx_cmd_o      <= ext_tx_cmd_i;
                    tx_k_o        <= ext_tx_k_i;
                    tx_wsync_o    <= ext_wsync_en_i;
                    tx_tmode_o    <= ext_tmode_i;
                    rx_valid_o    <= 1'b1;
                    rx_wclk_int_o <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lbk_channel_ctrl_chk.sv
module lbk_channel_ctrl_chk #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned TMODE_W = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [1:0]         mode_i,
    input logic               bist_en_i,
    input logic [BYTE_W-1:0]  ext_tx_byte_i,
    input logic               ext_tx_cmd_i,
    input logic               ext_tx_k_i,
    input logic               ext_wsync_en_i,
    input logic [TMODE_W-1:0] ext_tmode_i,
    input logic [BYTE_W-1:0]  rx_byte_i,
    input logic               rx_kflag_i,
    input logic [2:0]         rx_status_i,
    input logic               ser_tx_bit_i,
    input logic [BYTE_W-1:0]  tx_byte_o,
    input logic               tx_cmd_o,
    input logic               tx_k_o,
    input logic               tx_wsync_o,
    input logic [TMODE_W-1:0] tx_tmode_o,
    input logic               rx_valid_o,
    input logic               rx_wclk_int_o,
    input logic               cdr_in_o,
    input logic               ser_out_p_o,
    input logic               ser_out_r_o
);

    logic par_on, lost;
    assign par_on = (mode_i == 2'b01) && !bist_en_i;
    assign lost   = (rx_status_i == 3'b110) || (rx_status_i == 3'b111);

    // R2 R3 R10
    direct_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !par_on |=> (tx_byte_o == $past(ext_tx_byte_i)) && (tx_cmd_o == $past(ext_tx_cmd_i))
                 && (tx_k_o == $past(ext_tx_k_i)) && (tx_wsync_o == $past(ext_wsync_en_i))
                 && (tx_tmode_o == $past(ext_tmode_i)) && rx_valid_o && !rx_wclk_int_o);

    // R4
    par_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (par_on && !lost) |=> (tx_byte_o == $past(rx_byte_i)) && (tx_cmd_o == $past(rx_kflag_i)));

    // R5
    par_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        par_on |=> tx_k_o && !tx_wsync_o && (tx_tmode_o == '0) && rx_wclk_int_o && !rx_valid_o);

    // R6
    idle_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (par_on && lost) |=> (tx_byte_o == 8'hBC) && tx_cmd_o);

    // R8
    cdr_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b10) |=> (cdr_in_o == ser_tx_bit_i));

    // R9
    ser_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ser_out_p_o == ser_tx_bit_i) && (ser_out_r_o == ser_tx_bit_i));

endmodule

bind lbk_channel_ctrl lbk_channel_ctrl_chk #(
    .BYTE_W  (BYTE_W),
    .TMODE_W (TMODE_W)
) u_chk (.*);

// File: tb/lbk_channel_ctrl_bench.sv
module lbk_channel_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       bist = 1'b0;
    logic [7:0] ext_byte = '0;
    logic       ext_cmd = 1'b0, ext_k = 1'b0, ext_ws = 1'b0;
    logic [2:0] ext_tm = '0;
    logic [7:0] rx_byte = '0;
    logic       rx_k = 1'b0;
    logic [2:0] rx_st = '0;
    logic       stx = 1'b0, sline = 1'b0;

    logic [7:0] tx_byte;
    logic       tx_cmd, tx_k, tx_ws, rx_valid, wclk_int, cdr_in, sp, sr;
    logic [2:0] tx_tm;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lbk_channel_ctrl u_lbk_channel_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .bist_en_i(bist),
        .ext_tx_byte_i(ext_byte), .ext_tx_cmd_i(ext_cmd), .ext_tx_k_i(ext_k),
        .ext_wsync_en_i(ext_ws), .ext_tmode_i(ext_tm),
        .rx_byte_i(rx_byte), .rx_kflag_i(rx_k), .rx_status_i(rx_st),
        .ser_tx_bit_i(stx), .ser_line_rx_i(sline),
        .tx_byte_o(tx_byte), .tx_cmd_o(tx_cmd), .tx_k_o(tx_k), .tx_wsync_o(tx_ws),
        .tx_tmode_o(tx_tm), .rx_valid_o(rx_valid), .rx_wclk_int_o(wclk_int),
        .cdr_in_o(cdr_in), .ser_out_p_o(sp), .ser_out_r_o(sr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Applies the inputs at a falling edge, then waits to the next falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ext(input logic [7:0] b, input logic c, input logic k,
                           input logic w, input logic [2:0] t);
        ext_byte = b; ext_cmd = c; ext_k = k; ext_ws = w; ext_tm = t;
    endtask

    task automatic check_direct(input string req, input logic [7:0] b, input logic c,
                                input logic k, input logic w, input logic [2:0] t);
        check({req, " byte"}, 32'(tx_byte), 32'(b));
        check({req, " cmd"},  32'(tx_cmd), 32'(c));
        check({req, " k"},    32'(tx_k), 32'(k));
        check({req, " ws"},   32'(tx_ws), 32'(w));
        check({req, " tm"},   32'(tx_tm), 32'(t));
        check({req, " valid"}, 32'(rx_valid), 32'd1);
        check({req, " wclk"},  32'(wclk_int), 32'd0);
    endtask

    task automatic t_reset();
        sline = 1'b1; #1;
        check("R1 byte", 32'(tx_byte), 0);
        check("R1 ctrl", {27'd0, tx_cmd, tx_k, tx_ws, rx_valid, wclk_int}, 0);
        check("R1 tm", 32'(tx_tm), 0);
        check("R1 cdr", 32'(cdr_in), 1);
        sline = 1'b0; #1;
        check("R1 cdr0", 32'(cdr_in), 0);
    endtask

    task automatic t_normal();
        mode = 2'b00;
        set_ext(8'hA5, 1'b1, 1'b0, 1'b1, 3'b101);
        step();
        check_direct("R2 pat1", 8'hA5, 1'b1, 1'b0, 1'b1, 3'b101);
        set_ext(8'h3C, 1'b0, 1'b1, 1'b0, 3'b010);
        step();
        check_direct("R2 pat2", 8'h3C, 1'b0, 1'b1, 1'b0, 3'b010);
    endtask

    task automatic t_reserved();
        mode = 2'b11; rx_byte = 8'h11; rx_st = 3'b111;
        set_ext(8'h96, 1'b1, 1'b1, 1'b1, 3'b111);
        step();
        check_direct("R3 rsvd", 8'h96, 1'b1, 1'b1, 1'b1, 3'b111);
        sline = 1'b1; stx = 1'b0; #1;
        check("R3 cdr", 32'(cdr_in), 1);
        sline = 1'b0;
    endtask

    task automatic t_par_data();
        mode = 2'b01; bist = 1'b0;
        set_ext(8'hFF, 1'b0, 1'b0, 1'b1, 3'b111);
        rx_byte = 8'h5A; rx_k = 1'b0; rx_st = 3'b000;
        step();
        check("R4 data byte", 32'(tx_byte), 32'h5A);
        check("R4 data cmd", 32'(tx_cmd), 0);
        check("R5 k", 32'(tx_k), 1);
        check("R5 ws", 32'(tx_ws), 0);
        check("R5 tm", 32'(tx_tm), 0);
        check("R5 wclk", 32'(wclk_int), 1);
        check("R5 valid", 32'(rx_valid), 0);
        rx_byte = 8'h7C; rx_k = 1'b1; rx_st = 3'b001;
        step();
        check("R4 special byte", 32'(tx_byte), 32'h7C);
        check("R4 special cmd", 32'(tx_cmd), 1);
    endtask

    task automatic t_par_idle();
        mode = 2'b01;
        rx_byte = 8'h12; rx_k = 1'b0; rx_st = 3'b110;
        step();
        check("R6 resync byte", 32'(tx_byte), 32'hBC);
        check("R6 resync cmd", 32'(tx_cmd), 1);
        rx_byte = 8'hE3; rx_k = 1'b0; rx_st = 3'b111;
        step();
        check("R6 los byte", 32'(tx_byte), 32'hBC);
        check("R6 los cmd", 32'(tx_cmd), 1);
        rx_st = 3'b000;
        step();
        check("R4 recover byte", 32'(tx_byte), 32'hE3);
    endtask

    task automatic t_par_err();
        logic [2:0] codes [3] = '{3'b010, 3'b011, 3'b100};
        mode = 2'b01;
        foreach (codes[i]) begin
            rx_byte = 8'h40 + 8'(i); rx_k = 1'b0; rx_st = codes[i];
            step();
            check("R7 err byte", 32'(tx_byte), 32'h40 + i);
            check("R7 err cmd", 32'(tx_cmd), 0);
        end
    endtask

    task automatic t_serial();
        mode = 2'b10; sline = 1'b0; stx = 1'b1;
        set_ext(8'h81, 1'b1, 1'b0, 1'b0, 3'b011);
        step();
        check("R8 cdr hi", 32'(cdr_in), 1);
        check_direct("R8 tx path", 8'h81, 1'b1, 1'b0, 1'b0, 3'b011);
        stx = 1'b0; sline = 1'b1; #1;
        check("R8 cdr lo", 32'(cdr_in), 0);
        mode = 2'b00;
        step();
        check("R8 cdr back", 32'(cdr_in), 1);
        sline = 1'b0;
    endtask

    task automatic t_serout();
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            step();
            for (int b = 0; b < 2; b++) begin
                stx = 1'(b); #1;
                check("R9 p", 32'(sp), 32'(b));
                check("R9 r", 32'(sr), 32'(b));
            end
        end
    endtask

    task automatic t_bist();
        mode = 2'b01; bist = 1'b1;
        rx_byte = 8'h22; rx_st = 3'b111;
        set_ext(8'hC3, 1'b0, 1'b1, 1'b1, 3'b110);
        step();
        check_direct("R10 bist", 8'hC3, 1'b0, 1'b1, 1'b1, 3'b110);
        bist = 1'b0;
        step();
        check("R10 release", 32'(tx_byte), 32'hBC);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_normal();
        t_reserved();
        t_par_data();
        t_par_idle();
        t_par_err();
        t_serial();
        t_serout();
        t_bist();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule